// File: doc/BRIEF.md
# Bit-Stuffing Serial Frame Transmitter

This block turns a parallel frame into a single-wire serial stream. Software-facing logic upstream writes a 69-bit frame into the block's load register. A one-cycle send command, accepted only while the block reports itself ready, then starts serialisation on the next clock edge. Every bit on the wire lasts a fixed number of internal clocks, which by default is five. Data goes out least significant bit first.

To keep the line toggling, the transmitter watches the bits it has already placed on the wire. Once seven equal bits have gone out in a row and payload remains, it inserts one bit of the opposite value. The frame has no length field and no flag pattern. After the last payload bit, the transmitter sends eight equal bits, each the complement of that last payload bit. This run is long enough to break the stuffing rule, and a receiver takes that violation as end of transmission.

The line then returns to its high idle level. A quiet interval of 63 clocks must pass before the ready output rises again, which keeps the gap longer than a receiver's idle timeout.

Top module: `stuff_frame_tx`

## Requirements
- R1: After reset, `tx_line` is high and `tx_ready` is high.
- R2: A `send_req` sampled high while `tx_ready` is high lowers `tx_ready` and places frame bit 0 on `tx_line` at the same clock edge.
- R3: Every bit of a frame (payload, stuff or tail) is held on `tx_line` for exactly 5 clocks.
- R4: Payload bits are sent in order from bit 0 up to bit 68.
- R5: Suppose the last 7 bits on the wire within a frame all have one value and payload bits remain. The next wire bit is then a stuff bit of the opposite value. A stuff bit does not consume a payload bit, and it starts a new run of length 1.
- R6: After payload bit 68, exactly 8 tail bits follow, each the inverse of bit 68, and then `tx_line` returns high. No stuff bit is inserted after bit 68.
- R7: `tx_line` stays high and `tx_ready` stays low for 63 clocks after the line returns high, and `tx_ready` rises at the 63rd clock edge.
- R8: A `send_req` while `tx_ready` is low does not start or disturb a frame and does not shorten the quiet interval.
- R9: A `load_en` while `tx_ready` is low does not change the stored frame. A later send without a new load repeats the earlier frame.
- R10: When `load_en` and `send_req` are high in the same ready cycle, the frame sent is the newly loaded `load_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write strobe for the frame register, accepted while ready |
| load_data | input | 69 | Frame contents, bit 0 sent first |
| send_req | input | 1 | One-cycle command that starts a frame |
| tx_ready | output | 1 | High when no frame is in progress and the quiet interval has expired |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
Most internal faults in this block show up on `tx_line` within a single bit period. A wrong bit-timer limit changes the width of the first bit, and this is visible 5 clocks after the send. A run counter that is off by one moves a stuff bit by one bit slot, or drops it, as soon as the first 7-bit run of equal bits occurs. An error in the payload index corrupts the frame at the first payload bit it affects. A wrong tail length or quiet count shows up only after the whole frame, at the moment the line returns high or at the moment `tx_ready` rises.

// File: rtl/stuff_frame_tx_pkg.sv
package stuff_frame_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_DATA  = 2'd1,
      TX_TAIL  = 2'd2,
      TX_QUIET = 2'd3
   } tx_state_e;

endpackage

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
   parameter int BIT_CLKS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic tick
);
   localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

   generate
      if (BIT_CLKS == 1) begin : g_every
         assign tick = active;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!active || cnt_q == CW'(BIT_CLKS - 1))
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = active && (cnt_q == CW'(BIT_CLKS - 1));
      end
   endgenerate
endmodule

// File: rtl/sftx_run_tracker.sv
module sftx_run_tracker #(
   parameter int RUN_LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic emit,
   input  logic first,
   input  logic bit_val,
   output logic stuff_due,
   output logic stuff_val
);
   localparam int LW = $clog2(RUN_LEN + 1);

   logic [LW-1:0] len_q;
   logic          val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         val_q <= 1'b1;
      end else if (emit) begin
         val_q <= bit_val;
         if (first || bit_val != val_q)
            len_q <= LW'(1);
         else if (len_q != LW'(RUN_LEN))
            len_q <= len_q + 1'b1;
      end
   end

   assign stuff_due = (len_q == LW'(RUN_LEN));
   assign stuff_val = ~val_q;
endmodule

// File: rtl/sftx_quiet_timer.sv
module sftx_quiet_timer #(
   parameter int QUIET_CLKS = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic done
);
   localparam int QW = (QUIET_CLKS > 1) ? $clog2(QUIET_CLKS) : 1;

   generate
      if (QUIET_CLKS <= 1) begin : g_none
         assign done = active;
      end else begin : g_count
         logic [QW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!active || done)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign done = active && (cnt_q == QW'(QUIET_CLKS - 1));
      end
   endgenerate
endmodule

// File: rtl/stuff_frame_tx.sv
module stuff_frame_tx
   import stuff_frame_tx_pkg::*;
#(
   parameter int FRAME_W    = 69,
   parameter int BIT_CLKS   = 5,
   parameter int RUN_LEN    = 7,
   parameter int QUIET_CLKS = 63,
   parameter int HALF_BITS  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [FRAME_W-1:0] load_data,
   input  logic               send_req,
   output logic               tx_ready,
   output logic               tx_line
);
   localparam int TAIL_LEN = RUN_LEN + 1;
   localparam int CNT_W    = $clog2(FRAME_W + 1);
   localparam int TAIL_W   = $clog2(TAIL_LEN);
   localparam int TIMEOUT  = RUN_LEN * BIT_CLKS;
   localparam int HALF_GAP = HALF_BITS * (BIT_CLKS - 1) + 1;

   generate
      if (BIT_CLKS < 3) begin : g_chk_rate
         $error("BIT_CLKS must be at least 3");
      end
      if (RUN_LEN < 2) begin : g_chk_run
         $error("RUN_LEN must be at least 2");
      end
      if (FRAME_W < 2) begin : g_chk_frame
         $error("FRAME_W must be at least 2");
      end
      if (QUIET_CLKS <= TIMEOUT || QUIET_CLKS <= HALF_GAP) begin : g_chk_quiet
         $error("QUIET_CLKS must exceed the idle timeout and the half-buffer gap");
      end
   endgenerate

   tx_state_e            state_q, state_d;
   logic [FRAME_W-1:0]   frame_q, frame_d, load_val;
   logic [CNT_W-1:0]     sent_q, sent_d;
   logic [TAIL_W-1:0]    tail_q, tail_d;
   logic                 line_q, line_d;
   logic                 bit_tick, quiet_done;
   logic                 emit, first, emit_val;
   logic                 stuff_due, stuff_val;
   logic                 data_left;

   sftx_bit_timer #(.BIT_CLKS(BIT_CLKS)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == TX_DATA || state_q == TX_TAIL),
      .tick   (bit_tick)
   );

   sftx_run_tracker #(.RUN_LEN(RUN_LEN)) i_runs (
      .clk       (clk),
      .rst_n     (rst_n),
      .emit      (emit),
      .first     (first),
      .bit_val   (emit_val),
      .stuff_due (stuff_due),
      .stuff_val (stuff_val)
   );

   sftx_quiet_timer #(.QUIET_CLKS(QUIET_CLKS)) i_quiet (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == TX_QUIET),
      .done   (quiet_done)
   );

   assign load_val  = load_en ? load_data : frame_q;
   assign data_left = (sent_q != CNT_W'(FRAME_W));

   always_comb begin
      state_d  = state_q;
      frame_d  = frame_q;
      sent_d   = sent_q;
      tail_d   = tail_q;
      line_d   = line_q;
      emit     = 1'b0;
      first    = 1'b0;
      emit_val = 1'b1;
      unique case (state_q)
         TX_IDLE: begin
            line_d = 1'b1;
            if (load_en)
               frame_d = load_data;
            if (send_req) begin
               state_d  = TX_DATA;
               frame_d  = load_val;
               line_d   = load_val[0];
               sent_d   = CNT_W'(1);
               emit     = 1'b1;
               first    = 1'b1;
               emit_val = load_val[0];
            end
         end
         TX_DATA: begin
            if (bit_tick) begin
               if (!data_left) begin
                  state_d = TX_TAIL;
                  line_d  = ~frame_q[FRAME_W-1];
                  tail_d  = '0;
               end else if (stuff_due) begin
                  line_d   = stuff_val;
                  emit     = 1'b1;
                  emit_val = stuff_val;
               end else begin
                  line_d   = frame_q[sent_q];
                  sent_d   = sent_q + 1'b1;
                  emit     = 1'b1;
                  emit_val = frame_q[sent_q];
               end
            end
         end
         TX_TAIL: begin
            if (bit_tick) begin
               if (tail_q == TAIL_W'(TAIL_LEN - 1)) begin
                  state_d = TX_QUIET;
                  line_d  = 1'b1;
               end else begin
                  tail_d = tail_q + 1'b1;
               end
            end
         end
         TX_QUIET: begin
            line_d = 1'b1;
            if (quiet_done)
               state_d = TX_IDLE;
         end
         default: state_d = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         frame_q <= '0;
         sent_q  <= '0;
         tail_q  <= '0;
         line_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         frame_q <= frame_d;
         sent_q  <= sent_d;
         tail_q  <= tail_d;
         line_q  <= line_d;
      end
   end

   assign tx_ready = (state_q == TX_IDLE);
   assign tx_line  = line_q;
endmodule

// File: rtl/stuff_frame_tx_checker.sv
module stuff_frame_tx_checker
   import stuff_frame_tx_pkg::*;
#(
   parameter int BIT_CLKS = 5
) (
   input logic      clk,
   input logic      rst_n,
   input logic      send_req,
   input logic      tx_ready,
   input logic      tx_line,
   input tx_state_e st,
   input logic      tick,
   input logic      stuff_due,
   input logic      data_left
);
   localparam int HW = $clog2(BIT_CLKS + 1);

   logic          line_q;
   tx_state_e     st_q;
   logic [HW-1:0] hold_q;
   logic          in_frame_q;

   assign in_frame_q = (st_q == TX_DATA || st_q == TX_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b1;
         st_q   <= TX_IDLE;
         hold_q <= '0;
      end else begin
         line_q <= tx_line;
         st_q   <= st;
         if (tx_line != line_q || !in_frame_q || hold_q == HW'(BIT_CLKS - 1))
            hold_q <= '0;
         else
            hold_q <= hold_q + 1'b1;
      end
   end

   // R1, R7: an idle line sits high whenever a new frame may start
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_line);

   // R2: an accepted send drops ready on the next edge
   assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && send_req) |=> !tx_ready);

   // R3: a line change inside a frame lands on a whole bit period
   assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_line != line_q && in_frame_q) |-> (hold_q == HW'(BIT_CLKS - 1)));

   // R5: a full run with payload left is followed by an opposite bit
   assert_stuff_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_DATA && tick && stuff_due && data_left) |=> (tx_line != $past(tx_line)));

   // R7: during the quiet interval the line is high and ready is low
   assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_QUIET) |-> (tx_line && !tx_ready));
endmodule

bind stuff_frame_tx stuff_frame_tx_checker #(.BIT_CLKS(BIT_CLKS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .send_req  (send_req),
   .tx_ready  (tx_ready),
   .tx_line   (tx_line),
   .st        (state_q),
   .tick      (bit_tick),
   .stuff_due (stuff_due),
   .data_left (data_left)
);

// File: tb/test_stuff_frame_tx.sv
module test_stuff_frame_tx;
   localparam int FW    = 69;
   localparam int BCLK  = 5;
   localparam int RUN   = 7;
   localparam int TAILN = 8;
   localparam int QUIET = 63;
   localparam int NVEC  = 6;

   localparam logic [FW-1:0] VECS [NVEC] = '{
      69'h0_0000_0000_0000_0000,
      69'h1_FFFF_FFFF_FFFF_FFFF,
      69'h1_5555_5555_5555_5555,
      69'h0_0000_0000_0000_007F,
      69'h1_0000_0000_0000_003F,
      69'h0_DEAD_BEEF_1234_5678
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [FW-1:0] load_data = '0;
   logic          send_req = 1'b0;
   logic          tx_ready;
   logic          tx_line;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   bit  exp_bit [256];
   int  exp_req [256];
   int  nbits;

   always #4 clk = ~clk;

   stuff_frame_tx i_stuff_frame_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_data (load_data),
      .send_req  (send_req),
      .tx_ready  (tx_ready),
      .tx_line   (tx_line)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected wire bits: 4 = payload (R4), 5 = stuff (R5), 6 = tail (R6)
   task automatic build(input logic [FW-1:0] d);
      bit rv;
      int rl;
      nbits = 0;
      rv = 1'b1;
      rl = 0;
      for (int i = 0; i < FW; i++) begin
         if (rl == 0 || d[i] != rv) begin rv = d[i]; rl = 1; end
         else rl++;
         exp_bit[nbits] = d[i]; exp_req[nbits] = 4; nbits++;
         if (i < FW - 1 && rl == RUN) begin
            rv = ~rv; rl = 1;
            exp_bit[nbits] = rv; exp_req[nbits] = 5; nbits++;
         end
      end
      for (int t = 0; t < TAILN; t++) begin
         exp_bit[nbits] = ~d[FW-1]; exp_req[nbits] = 6; nbits++;
      end
   endtask

   task automatic load(input logic [FW-1:0] d);
      load_en = 1'b1; load_data = d;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   // mode 0: send only; 1: load and send together; 2: send, then disturb
   task automatic run_frame(input logic [FW-1:0] d, input int mode);
      build(d);
      send_req = 1'b1;
      if (mode == 1) begin load_en = 1'b1; load_data = d; end
      @(negedge clk);
      send_req = 1'b0; load_en = 1'b0;
      chk(tx_ready == 1'b0, "R2 ready low after send", tx_ready, 0);
      for (int n = 0; n < nbits; n++) begin
         chk(tx_line == exp_bit[n], (mode == 1) ? "R10 bit start" :
             (exp_req[n] == 4) ? "R4 payload bit" :
             (exp_req[n] == 5) ? "R5 stuff bit" : "R6 tail bit", tx_line, exp_bit[n]);
         for (int o = 1; o < BCLK; o++) begin
            @(negedge clk);
            if (mode == 2 && n == 10 && o == 1) begin
               send_req = 1'b1; load_en = 1'b1; load_data = ~d;
            end
            if (mode == 2 && n == 10 && o == 2) begin
               send_req = 1'b0; load_en = 1'b0;
            end
         end
         chk(tx_line == exp_bit[n], (mode == 2) ? "R8 bit end" : "R3 bit end", tx_line, exp_bit[n]);
         @(negedge clk);
      end
      chk(tx_line == 1'b1, "R6 line returns high", tx_line, 1);
      chk(tx_ready == 1'b0, "R7 ready low at quiet start", tx_ready, 0);
      for (int q = 1; q < QUIET; q++) begin
         @(negedge clk);
         if (mode == 2 && q == 5) begin
            send_req = 1'b1; load_en = 1'b1; load_data = ~d;
         end
         if (mode == 2 && q == 6) begin
            send_req = 1'b0; load_en = 1'b0;
            chk(tx_line == 1'b1, "R8 quiet line high", tx_line, 1);
         end
      end
      chk(tx_ready == 1'b0, "R7 ready low at quiet end", tx_ready, 0);
      chk(tx_line == 1'b1, "R7 line high in quiet", tx_line, 1);
      @(negedge clk);
      chk(tx_ready == 1'b1, "R7 ready after quiet", tx_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(tx_line == 1'b1, "R1 line high in reset", tx_line, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
      chk(tx_line == 1'b1, "R1 line idle", tx_line, 1);

      for (int v = 0; v < NVEC; v++) begin
         load(VECS[v]);
         run_frame(VECS[v], 0);
      end

      // R8 and R9: sends and loads while busy are ignored
      load(VECS[5]);
      run_frame(VECS[5], 2);
      run_frame(VECS[5], 0);

      // R10: load and send in the same cycle
      run_frame(69'h0_0F0F_00FF_F000_1234, 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule